// File: doc/BRIEF.md
# DTMF Dual-Tone Sample Generator

This block turns a 4-bit key code into a stream of signed digital samples. Each sample is the sum of one low-group (row) tone and one high-group (column) tone. Each tone comes from a 16-bit phase accumulator whose top eight bits drive a computed sine-like shape. The high group is scaled about 2 dB above the low group. An optional 6 dB cut halves the sum. The result is then clamped to the output width. The block runs on the system clock and advances once per sample strobe. The default constants assume a 3.579545 MHz clock divided by 448, which gives about 7990 samples per second.

The key code is captured only when the transmit enable goes high. Later changes on the code input are ignored until the next rising edge of the enable. While the enable is low the output is zero and both accumulators sit at zero, so every burst starts from the same phase. A synchronous power-down input clears all state.

Top module: `dtmf_gen`

## Requirements
- R1: The latched code selects the tone pair as follows. Rows 0..3 are 697, 770, 852 and 941 Hz. Columns 0..3 are 1209, 1336, 1477 and 1633 Hz. Codes 1..9 give row (code-1)/3 and column (code-1)%3. Code 10 gives row 3 / column 1. Code 11 gives row 3 / column 0. Code 12 gives row 3 / column 2. Codes 13, 14 and 15 give rows 0, 1 and 2 with column 3. Code 0 gives row 3 / column 3.
- R2: The code is captured at the clock edge where tx_en is high and was low at the previous edge. A code change at any other time has no effect on the output.
- R3: At every edge where tx_en is low, and at the edge where it rises, sample_out becomes 0 and both phases are reset to 0.
- R4: While tx_en is high and was high at the previous edge, an edge with sample_tick high loads sample_out with the value computed from the phases before they advance. An edge without sample_tick holds sample_out.
- R5: Each phase advances by round(f·65536·TICK_DIV/CLK_HZ) per tick, modulo 2^16. Its top 8 bits idx give the shape value p·(127−p), where p = idx[6:0]. The value is negated when idx[7] is 1.
- R6: The low tone is the shape value unchanged. The high tone is floor(shape·323/256), a gain of about +2.0 dB.
- R7: With atten high, the summed value is arithmetically shifted right by one (−6 dB) before clamping.
- R8: The result is clamped to the signed range of OUT_W bits, which is −8192..8191 by default.
- R9: While powerdown is high, sample_out goes to 0 at the next edge, the phases clear and the enable history clears. If tx_en is high when powerdown releases, that counts as a new rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| powerdown | input | 1 | Synchronous active-high reset and power-down |
| sample_tick | input | 1 | One-cycle sample-rate strobe |
| tx_en | input | 1 | Active-high transmit enable; its rising edge captures the code |
| key_code | input | 4 | Key code, mapped as in R1 |
| atten | input | 1 | Selects the 6 dB cut |
| sample_out | output | OUT_W | Signed two-tone sample |

## Verification
Two events collide in the same cycle. The enable can rise on the same edge as a sample strobe, and a code change can land on that same rising edge. The bench drives the strobe on every cycle through a rising edge to provoke this. It expects a zero sample and no phase advance on that edge, followed by the newly presented code. Power-down arriving alongside strobes with the enable held high is also provoked. Each of these is judged cycle by cycle against a scoreboard model that tracks phases, code capture and clamping.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;

    localparam int PH_W    = 16;   // phase accumulator width
    localparam int IDX_W   = 8;    // phase bits used by the shape
    localparam int SHAPE_W = 14;   // signed shape width
    localparam int LVL_W   = 16;   // signed per-tone level width
    localparam int KEY_W   = 4;
    localparam int HALF_MAX = (1 << (IDX_W - 1)) - 1;

    // high group gain 323/256 ~ +2.0 dB
    localparam int HI_GAIN_NUM = 323;
    localparam int LO_GAIN_NUM = 256;
    localparam int GAIN_SHIFT  = 8;

    typedef struct packed {
        logic [1:0] row;
        logic [1:0] col;
    } key_pos_t;

    function automatic int row_hz(input int i);
        case (i)
            0: return 697;
            1: return 770;
            2: return 852;
            default: return 941;
        endcase
    endfunction

    function automatic int col_hz(input int i);
        case (i)
            0: return 1209;
            1: return 1336;
            2: return 1477;
            default: return 1633;
        endcase
    endfunction

    function automatic logic [PH_W-1:0] phase_inc(input int hz, input int clk_hz, input int div);
        longint num;
        num = longint'(hz) * (longint'(1) << PH_W) * longint'(div);
        return PH_W'((num + longint'(clk_hz / 2)) / longint'(clk_hz));
    endfunction

    function automatic key_pos_t decode_key(input logic [KEY_W-1:0] c);
        key_pos_t k;
        case (c)
            4'd0:  k = '{row: 2'd3, col: 2'd3};
            4'd10: k = '{row: 2'd3, col: 2'd1};
            4'd11: k = '{row: 2'd3, col: 2'd0};
            4'd12: k = '{row: 2'd3, col: 2'd2};
            4'd13, 4'd14, 4'd15: k = '{row: 2'(c - 4'd13), col: 2'd3};
            default: begin
                k.row = 2'((c - 4'd1) / 4'd3);
                k.col = 2'((c - 4'd1) % 4'd3);
            end
        endcase
        return k;
    endfunction

    // parabolic half-wave, sign from the top index bit
    function automatic logic signed [SHAPE_W-1:0] tone_shape(input logic [IDX_W-1:0] idx);
        int p;
        int m;
        p = int'(idx[IDX_W-2:0]);
        m = p * (HALF_MAX - p);
        return idx[IDX_W-1] ? -SHAPE_W'(m) : SHAPE_W'(m);
    endfunction

endpackage

// File: rtl/dtmf_keymap.sv
module dtmf_keymap
    import dtmf_pkg::*;
#(
    parameter int CLK_HZ   = 3579545,
    parameter int TICK_DIV = 448
) (
    input  logic [KEY_W-1:0] code,
    output logic [PH_W-1:0]  inc_lo,
    output logic [PH_W-1:0]  inc_hi
);

    localparam int GROUP_N = 4;

    logic [PH_W-1:0] row_inc [GROUP_N];
    logic [PH_W-1:0] col_inc [GROUP_N];
    key_pos_t pos;

    for (genvar gi = 0; gi < GROUP_N; gi++) begin : g_inc
        assign row_inc[gi] = phase_inc(row_hz(gi), CLK_HZ, TICK_DIV);
        assign col_inc[gi] = phase_inc(col_hz(gi), CLK_HZ, TICK_DIV);
    end

    always_comb begin
        pos    = decode_key(code);
        inc_lo = row_inc[pos.row];
        inc_hi = col_inc[pos.col];
    end

endmodule

// File: rtl/dtmf_tone_osc.sv
module dtmf_tone_osc
    import dtmf_pkg::*;
#(
    parameter int GAIN_NUM = 256,
    parameter int G_SHIFT  = 8
) (
    input  logic                    clk,
    input  logic                    clear,
    input  logic                    advance,
    input  logic [PH_W-1:0]         inc,
    output logic signed [LVL_W-1:0] level
);

    localparam int PROD_W = SHAPE_W + 12;

    logic [PH_W-1:0]            phase;
    logic signed [SHAPE_W-1:0]  shp;
    logic signed [PROD_W-1:0]   prod;

    always_ff @(posedge clk) begin
        if (clear)
            phase <= '0;
        else if (advance)
            phase <= phase + inc;
    end

    always_comb begin
        shp   = tone_shape(phase[PH_W-1 -: IDX_W]);
        prod  = PROD_W'(shp) * PROD_W'(GAIN_NUM);
        level = LVL_W'(prod >>> G_SHIFT);
    end

endmodule

// File: rtl/dtmf_mix.sv
module dtmf_mix
    import dtmf_pkg::*;
#(
    parameter int OUT_W = 14
) (
    input  logic signed [LVL_W-1:0] lo,
    input  logic signed [LVL_W-1:0] hi,
    input  logic                    atten,
    output logic signed [OUT_W-1:0] mixed
);

    localparam int SUM_W = LVL_W + 1;
    localparam logic signed [SUM_W-1:0] MAX_V = SUM_W'((1 << (OUT_W - 1)) - 1);
    localparam logic signed [SUM_W-1:0] MIN_V = -SUM_W'(1 << (OUT_W - 1));

    logic signed [SUM_W-1:0] sum;
    logic signed [SUM_W-1:0] scaled;

    always_comb begin
        sum    = SUM_W'(lo) + SUM_W'(hi);
        scaled = atten ? (sum >>> 1) : sum;
        if (scaled > MAX_V)
            mixed = OUT_W'(MAX_V);
        else if (scaled < MIN_V)
            mixed = OUT_W'(MIN_V);
        else
            mixed = OUT_W'(scaled);
    end

endmodule

// File: rtl/dtmf_gen.sv
module dtmf_gen
    import dtmf_pkg::*;
#(
    parameter int CLK_HZ   = 3579545,
    parameter int TICK_DIV = 448,
    parameter int OUT_W    = 14
) (
    input  logic                    clk,
    input  logic                    powerdown,
    input  logic                    sample_tick,
    input  logic                    tx_en,
    input  logic [KEY_W-1:0]        key_code,
    input  logic                    atten,
    output logic signed [OUT_W-1:0] sample_out
);

    logic                    en_d;
    logic [KEY_W-1:0]        code_q;
    logic                    active;
    logic                    osc_clear;
    logic                    osc_adv;
    logic [PH_W-1:0]         inc_lo;
    logic [PH_W-1:0]         inc_hi;
    logic signed [LVL_W-1:0] lvl_lo;
    logic signed [LVL_W-1:0] lvl_hi;
    logic signed [OUT_W-1:0] mixed;

    assign active    = tx_en & en_d;
    assign osc_clear = powerdown | ~active;
    assign osc_adv   = active & sample_tick;

    dtmf_keymap #(.CLK_HZ(CLK_HZ), .TICK_DIV(TICK_DIV)) u_map (
        .code   (code_q),
        .inc_lo (inc_lo),
        .inc_hi (inc_hi)
    );

    dtmf_tone_osc #(.GAIN_NUM(LO_GAIN_NUM), .G_SHIFT(GAIN_SHIFT)) u_osc_lo (
        .clk     (clk),
        .clear   (osc_clear),
        .advance (osc_adv),
        .inc     (inc_lo),
        .level   (lvl_lo)
    );

    dtmf_tone_osc #(.GAIN_NUM(HI_GAIN_NUM), .G_SHIFT(GAIN_SHIFT)) u_osc_hi (
        .clk     (clk),
        .clear   (osc_clear),
        .advance (osc_adv),
        .inc     (inc_hi),
        .level   (lvl_hi)
    );

    dtmf_mix #(.OUT_W(OUT_W)) u_mix (
        .lo    (lvl_lo),
        .hi    (lvl_hi),
        .atten (atten),
        .mixed (mixed)
    );

    always_ff @(posedge clk) begin
        if (powerdown) begin
            en_d       <= 1'b0;
            code_q     <= '0;
            sample_out <= '0;
        end else begin
            en_d <= tx_en;
            if (tx_en && !en_d)
                code_q <= key_code;
            if (!active)
                sample_out <= '0;
            else if (sample_tick)
                sample_out <= mixed;
        end
    end

endmodule

// File: rtl/dtmf_gen_chk.sv
module dtmf_gen_chk #(
    parameter int OUT_W = 14
) (
    input logic                    clk,
    input logic                    powerdown,
    input logic                    sample_tick,
    input logic                    tx_en,
    input logic                    atten,
    input logic                    en_d,
    input logic [3:0]              code_q,
    input logic signed [OUT_W-1:0] sample_out
);

    // R3: enable low gives a zero sample on the next edge
    a_r3_idle_zero: assert property (@(posedge clk) disable iff (powerdown)
        !tx_en |=> sample_out == '0);

    // R3: the rising edge of the enable also yields zero
    a_r3_rise_zero: assert property (@(posedge clk) disable iff (powerdown)
        (tx_en && !en_d) |=> sample_out == '0);

    // R9: power-down forces zero
    a_r9_pd_zero: assert property (@(posedge clk)
        powerdown |=> sample_out == '0);

    // R2: captured code is stable through a burst
    a_r2_code_hold: assert property (@(posedge clk) disable iff (powerdown)
        (tx_en && en_d) |=> $stable(code_q));

    // R4: no strobe while running means the sample holds
    a_r4_hold: assert property (@(posedge clk) disable iff (powerdown)
        (tx_en && en_d && !sample_tick) |=> $stable(sample_out));

    // R7: attenuated samples stay within half the unclamped peak
    a_r7_att_range: assert property (@(posedge clk) disable iff (powerdown)
        (tx_en && en_d && sample_tick && atten) |=>
            (sample_out <= 4560 && sample_out >= -4560));

endmodule

bind dtmf_gen dtmf_gen_chk #(.OUT_W(OUT_W)) u_chk (
    .clk         (clk),
    .powerdown   (powerdown),
    .sample_tick (sample_tick),
    .tx_en       (tx_en),
    .atten       (atten),
    .en_d        (en_d),
    .code_q      (code_q),
    .sample_out  (sample_out)
);

// File: tb/dtmf_gen_test.sv
`timescale 1ns/1ps
module dtmf_gen_test;

    localparam int    OUT_W    = 14;
    localparam real   CLK_HZ   = 3579545.0;
    localparam real   TICK_DIV = 448.0;
    localparam int    OMAX     = (1 << (OUT_W - 1)) - 1;
    localparam int    OMIN     = -(1 << (OUT_W - 1));

    logic clk = 1'b0;
    logic powerdown = 1'b1;
    logic sample_tick = 1'b0;
    logic tx_en = 1'b0;
    logic [3:0] key_code = 4'd0;
    logic atten = 1'b0;
    logic signed [OUT_W-1:0] sample_out;

    always #4 clk = ~clk;

    dtmf_gen uut (
        .clk         (clk),
        .powerdown   (powerdown),
        .sample_tick (sample_tick),
        .tx_en       (tx_en),
        .key_code    (key_code),
        .atten       (atten),
        .sample_out  (sample_out)
    );

    typedef struct {
        int    val;
        string tag;
    } exp_t;

    exp_t q[$];
    int total = 0;
    int bad = 0;
    int sat_hits = 0;
    bit done = 1'b0;

    // scoreboard model state
    int  m_ph_lo = 0, m_ph_hi = 0, m_inc_lo = 0, m_inc_hi = 0, m_out = 0;
    bit  m_en_d = 1'b0;

    // R1 key map written out independently
    int row_of [16] = '{3,0,0,0,1,1,1,2,2,2,3,3,3,0,1,2};
    int col_of [16] = '{3,0,1,2,0,1,2,0,1,2,1,0,2,3,3,3};
    real row_f [4] = '{697.0, 770.0, 852.0, 941.0};
    real col_f [4] = '{1209.0, 1336.0, 1477.0, 1633.0};

    function automatic int inc_of(real f);
        return $rtoi(f * 65536.0 * TICK_DIV / CLK_HZ + 0.5);
    endfunction

    function automatic int shp(int idx);
        int p;
        p = idx % 128;
        return (idx >= 128) ? -(p * (127 - p)) : p * (127 - p);
    endfunction

    function automatic int mix(int plo, int phi, bit att, output bit sat);
        int s;
        s = shp(plo >> 8) + ((shp(phi >> 8) * 323) >>> 8);
        if (att) s = s >>> 1;
        sat = 1'b0;
        if (s > OMAX) begin s = OMAX; sat = 1'b1; end
        if (s < OMIN) begin s = OMIN; sat = 1'b1; end
        return s;
    endfunction

    // driver: one cycle of stimulus plus its expected result
    task automatic cyc(bit pd, bit tk, bit en, logic [3:0] code, bit att, string tag);
        bit sat;
        @(negedge clk);
        powerdown = pd; sample_tick = tk; tx_en = en; key_code = code; atten = att;
        if (pd) begin
            m_en_d = 1'b0; m_out = 0; m_ph_lo = 0; m_ph_hi = 0;
        end else begin
            if (en && !m_en_d) begin
                m_inc_lo = inc_of(row_f[row_of[code]]);
                m_inc_hi = inc_of(col_f[col_of[code]]);
            end
            if (!(en && m_en_d)) begin
                m_out = 0; m_ph_lo = 0; m_ph_hi = 0;
            end else if (tk) begin
                m_out = mix(m_ph_lo, m_ph_hi, att, sat);
                if (sat) sat_hits++;
                m_ph_lo = (m_ph_lo + m_inc_lo) % 65536;
                m_ph_hi = (m_ph_hi + m_inc_hi) % 65536;
            end
            m_en_d = en;
        end
        q.push_back('{m_out, tag});
    endtask

    task automatic run(int n, bit en, logic [3:0] code, bit att, int every, string tag);
        for (int i = 0; i < n; i++)
            cyc(1'b0, (i % every) == (every - 1), en, code, att, tag);
    endtask

    // monitor: compares after each edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                total++;
                if (int'(sample_out) != e.val) begin
                    bad++;
                    $display("FAIL %s: sample_out=%0d expected=%0d at %0t", e.tag, int'(sample_out), e.val, $time);
                end
            end
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R9 reset state
        for (int i = 0; i < 4; i++) cyc(1'b1, 1'b1, 1'b0, 4'd3, 1'b0, "R9_reset");
        // R3 idle with strobes
        run(12, 1'b0, 4'd5, 1'b0, 1, "R3_idle");
        // R1, R5, R6: every code, strobe on every cycle including the rising edge
        for (int c = 0; c < 16; c++) begin
            run(120, 1'b1, 4'(c), 1'b0, 1, "R1_R5_R6_code");
            run(3, 1'b0, 4'(c), 1'b0, 1, "R3_gap");
        end
        // R2: code changes during a burst are ignored
        run(40, 1'b1, 4'd5, 1'b0, 2, "R2_latch");
        run(80, 1'b1, 4'd9, 1'b0, 2, "R2_ignore");
        run(2, 1'b0, 4'd9, 1'b0, 1, "R3_gap");
        // R2: new burst takes the presented code
        run(60, 1'b1, 4'd12, 1'b0, 1, "R2_newcode");
        run(2, 1'b0, 4'd12, 1'b0, 1, "R3_gap");
        // R4: irregular strobes hold between updates
        for (int i = 0; i < 150; i++)
            cyc(1'b0, (i % 7 == 0) || (i % 7 == 1) || (i % 11 == 3), 1'b1, 4'd7, 1'b0, "R4_strobe");
        run(2, 1'b0, 4'd7, 1'b0, 1, "R3_gap");
        // R7: attenuation, toggled mid-burst
        run(300, 1'b1, 4'd0, 1'b1, 1, "R7_atten");
        run(100, 1'b1, 4'd0, 1'b0, 1, "R7_release");
        run(2, 1'b0, 4'd0, 1'b0, 1, "R3_gap");
        // R8: long loud bursts hit the clamp
        sat_hits = 0;
        run(2000, 1'b1, 4'd0, 1'b0, 1, "R8_clamp");
        run(2, 1'b0, 4'd0, 1'b0, 1, "R3_gap");
        run(2000, 1'b1, 4'd15, 1'b0, 1, "R8_clamp");
        // R9: power-down mid-burst with enable held, then restart
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, 1'b1, 4'd15, 1'b0, "R9_pd_mid");
        run(80, 1'b1, 4'd2, 1'b0, 1, "R9_restart");
        run(4, 1'b0, 4'd2, 1'b0, 1, "R3_end");
        repeat (4) @(posedge clk);
        #3;
        total++;
        if (sat_hits == 0) begin
            bad++;
            $display("FAIL R8: clamp events=%0d expected=>0", sat_hits);
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule